// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns single-word memory requests into SDRAM command sequences and carries out the maintenance operations that software asks for through a set of control inputs. Each accepted request runs a closed-page sequence: row activate, column read or write, then a precharge of that bank. Commands leave the block on the standard active-low chip-select, row-strobe, column-strobe and write-enable lines, together with bank, address and clock-enable outputs.

Software sets the column width, the write recovery time and a refresh-disable level. It also pulses one-cycle strobes to arm the power-up sequence, request self-refresh, force an auto-refresh or force a precharge-all. Arming power-up does nothing on its own. The initialisation runs in front of the next access, and that access waits until initialisation is complete. Self-refresh entry waits for the access in progress to finish. A later request wakes the memory before that request is served.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command lines carry NOP ({cs,ras,cas,we} = 0111), clock enable is high, busy is low and ready is high.
- R2: Column width code 00/01/10/11 selects 8/9/10/11 column bits. The address splits from the low end as column, then 2 bank bits, then 13 row bits. On READ/WRITE the column bits 9:0 go to address bits 9:0, column bit 10 goes to address bit 11, and address bit 10 is 0.
- R3: The power-up strobe alone issues no command. The next accepted request is preceded by PRECHARGE-all, REFRESH, REFRESH and MODE SET (address 0x020), spaced 2, 4, 4 cycles, with ACTIVATE 2 cycles after MODE SET.
- R4: An access issues ACTIVATE (row), then READ or WRITE 2 cycles later, then a single-bank PRECHARGE (address bit 10 low). Done is high only in that PRECHARGE cycle.
- R5: For a write, PRECHARGE follows WRITE by tWR+1 cycles, with tWR code 1..3 in cycles and code 0 treated as 1. For a read, PRECHARGE follows READ by 1 cycle.
- R6: The self-refresh strobe leads to a REFRESH with clock enable low once any access in progress has completed. Clock enable then stays low and no command is issued until a request arrives.
- R7: A request during self-refresh raises clock enable with NOP and issues ACTIVATE 3 cycles later.
- R8: With refresh-disable 0, a REFRESH is issued every refresh period while idle. With refresh-disable 1, expiry of the period issues nothing.
- R9: The force-refresh strobe issues one REFRESH as soon as the sequencer is idle.
- R10: The force-precharge strobe issues a PRECHARGE-all (address bit 10 high). When both force strobes arrive together, the PRECHARGE comes before the REFRESH.
- R11: Pending forced or counter refresh work is served before new requests, ready is low while it is pending, and it never breaks into a running sequence.
- R12: Command encodings are MRS 0000, REF 0001, PRE 0010, ACT 0011, WR 0100, RD 0101 and NOP 0111. NOP is driven whenever no command is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Linear word address |
| req_ready_o | output | 1 | Request taken when valid and ready are both high |
| req_done_o | output | 1 | Access finishing (its precharge cycle) |
| cfg_col_w_i | input | 2 | Column width code |
| cfg_twr_i | input | 2 | Write recovery cycles |
| cfg_ref_off_i | input | 1 | Disable periodic refresh |
| ctl_pwrup_i | input | 1 | Strobe: arm power-up sequence |
| ctl_sref_i | input | 1 | Strobe: enter self-refresh |
| ctl_fref_i | input | 1 | Strobe: force auto-refresh |
| ctl_fpre_i | input | 1 | Strobe: force precharge-all |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_cke_o | output | 1 | Clock enable |
| sd_ba_o | output | BA_W | Bank address |
| sd_a_o | output | ROW_W | Row/column/mode address |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume a few things about the inputs. The fixed activate-to-column delay and the write recovery are at least one idle cycle each. Reset is held for at least one clock edge, and clock enable is high during reset. Strobes are one cycle wide. The configuration inputs stay stable while an access is in flight. The stimulus meets these conditions: it drives every input at the falling edge, changes the configuration only while the sequencer is idle, and pulses each strobe for exactly one cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_IPRE, S_IREF1, S_IREF2, S_IMRS, S_ACT, S_RD,
    S_WR, S_PRE, S_FPRE, S_REF, S_SRE, S_SREF, S_SRX
  } seq_state_e;
endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int ADDR_W = 24,
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        col_w_i,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [ROW_W-1:0]  col_a_o
);
  localparam int MAX_COL = 11;

  logic [3:0]         cw;
  logic [MAX_COL-1:0] mask;
  logic [MAX_COL-1:0] col;
  logic [ADDR_W-1:0]  rest;

  always_comb begin
    cw   = 4'd8 + {2'b00, col_w_i};
    mask = ~({MAX_COL{1'b1}} << cw);
    col  = addr_i[MAX_COL-1:0] & mask;
    rest = addr_i >> cw;
  end

  assign ba_o  = rest[BA_W-1:0];
  assign row_o = rest[BA_W +: ROW_W];

  // bit 10 is the all-bank flag, so column bit 10 moves up to bit 11
  for (genvar i = 0; i < ROW_W; i++) begin : g_col
    if (i < 10) begin : g_lo
      assign col_a_o[i] = col[i];
    end else if (i == 11) begin : g_hi
      assign col_a_o[i] = col[10];
    end else begin : g_zero
      assign col_a_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int PERIOD = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BA_W       = 2,
  parameter int ROW_W      = 13,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 4,
  parameter int T_MRD      = 2,
  parameter int T_XSR      = 3,
  parameter int REF_PERIOD = 390,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              req_done_o,
  input  logic [1:0]        cfg_col_w_i,
  input  logic [1:0]        cfg_twr_i,
  input  logic              cfg_ref_off_i,
  input  logic              ctl_pwrup_i,
  input  logic              ctl_sref_i,
  input  logic              ctl_fref_i,
  input  logic              ctl_fpre_i,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic              sd_cke_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ROW_W-1:0]  sd_a_o,
  output logic              busy_o
);
  localparam int DLY_W = $clog2(T_RCD + T_RP + T_RFC + T_MRD + T_XSR + 6);

  seq_state_e st_q, st_d, nxt_q, nxt_d, tgt;
  logic [DLY_W-1:0] cnt_q, cnt_d, dly;
  logic go;
  sd_cmd_e cmd;

  logic pu_arm_q, sref_q, fref_q, fpre_q, rpend_q;
  logic clr_pu, clr_sref, clr_fref, clr_fpre;
  logic ref_tick, accept;

  logic             wr_q;
  logic [BA_W-1:0]  ba_q, sp_ba;
  logic [ROW_W-1:0] row_q, col_q, sp_row, sp_col;
  logic [1:0]       twr_eff;

  sdram_addr_split #(.ADDR_W(ADDR_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_split (
    .addr_i (req_addr_i),
    .col_w_i(cfg_col_w_i),
    .ba_o   (sp_ba),
    .row_o  (sp_row),
    .col_a_o(sp_col)
  );

  sdram_ref_timer #(.PERIOD(REF_PERIOD)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(ref_tick)
  );

  assign req_ready_o = (st_q == S_IDLE && !(fpre_q || fref_q || rpend_q || sref_q))
                       || st_q == S_SREF;
  assign accept  = req_valid_i && req_ready_o;
  assign busy_o  = !(st_q == S_IDLE || st_q == S_SREF);
  assign twr_eff = (cfg_twr_i == 2'd0) ? 2'd1 : cfg_twr_i;
  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

  always_comb begin
    st_d = st_q;  nxt_d = nxt_q;  cnt_d = cnt_q;
    go = 1'b0;  dly = '0;  tgt = S_IDLE;
    cmd = CMD_NOP;  sd_ba_o = '0;  sd_a_o = '0;  sd_cke_o = 1'b1;  req_done_o = 1'b0;
    clr_pu = 1'b0;  clr_sref = 1'b0;  clr_fref = 1'b0;  clr_fpre = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (fpre_q)                st_d = S_FPRE;
        else if (fref_q || rpend_q) st_d = S_REF;
        else if (sref_q)           st_d = S_SRE;
        else if (accept)           st_d = pu_arm_q ? S_IPRE : S_ACT;
      end
      S_WAIT: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == DLY_W'(1)) st_d = nxt_q;
      end
      S_FPRE: begin
        cmd = CMD_PRE;  sd_a_o[10] = 1'b1;  clr_fpre = 1'b1;
        go = 1'b1;  dly = DLY_W'(T_RP);  tgt = S_IDLE;
      end
      S_REF: begin
        cmd = CMD_REF;  clr_fref = 1'b1;
        go = 1'b1;  dly = DLY_W'(T_RFC);  tgt = S_IDLE;
      end
      S_SRE: begin
        cmd = CMD_REF;  sd_cke_o = 1'b0;  clr_sref = 1'b1;
        st_d = S_SREF;
      end
      S_SREF: begin
        sd_cke_o = 1'b0;
        if (accept) st_d = S_SRX;
      end
      S_SRX: begin
        go = 1'b1;  dly = DLY_W'(T_XSR);  tgt = pu_arm_q ? S_IPRE : S_ACT;
      end
      S_IPRE: begin
        cmd = CMD_PRE;  sd_a_o[10] = 1'b1;  clr_pu = 1'b1;
        go = 1'b1;  dly = DLY_W'(T_RP);  tgt = S_IREF1;
      end
      S_IREF1: begin
        cmd = CMD_REF;  go = 1'b1;  dly = DLY_W'(T_RFC);  tgt = S_IREF2;
      end
      S_IREF2: begin
        cmd = CMD_REF;  go = 1'b1;  dly = DLY_W'(T_RFC);  tgt = S_IMRS;
      end
      S_IMRS: begin
        cmd = CMD_MRS;  sd_a_o = MODE_WORD;
        go = 1'b1;  dly = DLY_W'(T_MRD);  tgt = S_ACT;
      end
      S_ACT: begin
        cmd = CMD_ACT;  sd_ba_o = ba_q;  sd_a_o = row_q;
        go = 1'b1;  dly = DLY_W'(T_RCD);  tgt = wr_q ? S_WR : S_RD;
      end
      S_RD: begin
        cmd = CMD_RD;  sd_ba_o = ba_q;  sd_a_o = col_q;
        go = 1'b1;  dly = DLY_W'(1);  tgt = S_PRE;
      end
      S_WR: begin
        cmd = CMD_WR;  sd_ba_o = ba_q;  sd_a_o = col_q;
        go = 1'b1;  dly = DLY_W'(twr_eff) + 1'b1;  tgt = S_PRE;
      end
      S_PRE: begin
        cmd = CMD_PRE;  sd_ba_o = ba_q;  req_done_o = 1'b1;
        go = 1'b1;  dly = DLY_W'(T_RP);  tgt = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (go) begin
      if (dly <= DLY_W'(1)) st_d = tgt;
      else begin
        st_d = S_WAIT;  cnt_d = dly - 1'b1;  nxt_d = tgt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  nxt_q <= S_IDLE;  cnt_q <= '0;
      pu_arm_q <= 1'b0;  sref_q <= 1'b0;  fref_q <= 1'b0;  fpre_q <= 1'b0;  rpend_q <= 1'b0;
      wr_q <= 1'b0;  ba_q <= '0;  row_q <= '0;  col_q <= '0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
      cnt_q <= cnt_d;
      pu_arm_q <= (pu_arm_q && !clr_pu)   || ctl_pwrup_i;
      sref_q   <= (sref_q   && !clr_sref) || ctl_sref_i;
      fref_q   <= (fref_q   && !clr_fref) || ctl_fref_i;
      fpre_q   <= (fpre_q   && !clr_fpre) || ctl_fpre_i;
      rpend_q  <= (rpend_q  && !clr_fref) ||
                  (ref_tick && !cfg_ref_off_i && st_q != S_SREF && st_q != S_SRE);
      if (accept) begin
        wr_q  <= req_write_i;
        ba_q  <= sp_ba;
        row_q <= sp_row;
        col_q <= sp_col;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             req_done_o,
  input logic             sd_cs_n_o,
  input logic             sd_ras_n_o,
  input logic             sd_cas_n_o,
  input logic             sd_we_n_o,
  input logic             sd_cke_o,
  input logic [BA_W-1:0]  sd_ba_o,
  input logic [ROW_W-1:0] sd_a_o,
  input logic             busy_o
);
  logic [3:0] c;
  assign c = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};

  assert_ready_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !busy_o);
  assert_act_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c == 4'b0011 |=> c == 4'b0111);
  assert_wr_rec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c == 4'b0100 |=> c == 4'b0111);
  assert_done_bank_pre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> (c == 4'b0010 && !sd_a_o[10]));
  assert_force_pre_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == 4'b0010 && !req_done_o) |-> sd_a_o[10]);
  assert_cke_low_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_cke_o |-> (c == 4'b0111 || c == 4'b0001));
  assert_sr_entry_ref_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_cke_o) |-> c == 4'b0001);
  assert_sr_exit_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_cke_o) |-> c == 4'b0111);
  assert_idle_nop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sd_cke_o) |-> c == 4'b0111);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.BA_W(BA_W), .ROW_W(ROW_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .req_done_o (req_done_o),
  .sd_cs_n_o  (sd_cs_n_o),
  .sd_ras_n_o (sd_ras_n_o),
  .sd_cas_n_o (sd_cas_n_o),
  .sd_we_n_o  (sd_we_n_o),
  .sd_cke_o   (sd_cke_o),
  .sd_ba_o    (sd_ba_o),
  .sd_a_o     (sd_a_o),
  .busy_o     (busy_o)
);

// File: tb/sdram_cmd_seq_tb_top.sv
module sdram_cmd_seq_tb_top;
  localparam int REF_P = 390;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111, C_CKE = 4'b1111;

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] a;
    bit          chk_a;
    logic        cke;
    logic        done;
    int          gap;
    string       rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0] col_w = 2'd0, twr = 2'd1;
  logic ref_off = 1'b1, s_pu = 1'b0, s_sr = 1'b0, s_fr = 1'b0, s_fp = 1'b0;
  logic req_ready, req_done, cs_n, ras_n, cas_n, we_n, cke, busy;
  logic [1:0]  ba;
  logic [12:0] a;

  exp_t exp_q[$];
  int total = 0, bad = 0, cyc = 0, last_cyc = 0, n_evt = 0, wd = 0;
  logic prev_cke = 1'b1;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.REF_PERIOD(REF_P)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .req_done_o(req_done),
    .cfg_col_w_i(col_w), .cfg_twr_i(twr), .cfg_ref_off_i(ref_off),
    .ctl_pwrup_i(s_pu), .ctl_sref_i(s_sr), .ctl_fref_i(s_fr), .ctl_fpre_i(s_fp),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_cke_o(cke), .sd_ba_o(ba), .sd_a_o(a), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] ad,
                      input bit ca, input logic ck, input logic dn, input int gap, input string rq);
    exp_t e;
    e.cmd = c; e.ba = b; e.a = ad; e.chk_a = ca; e.cke = ck; e.done = dn; e.gap = gap; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic handle(input logic [3:0] c);
    exp_t e;
    bit ok;
    total++;
    n_evt++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R12 unexpected command: actual=%0h expected=none", c);
    end else begin
      e = exp_q.pop_front();
      ok = (c == e.cmd) && (cke == e.cke) && (req_done == e.done) &&
           (!e.chk_a || (ba == e.ba && a == e.a)) && (e.gap < 0 || cyc - last_cyc == e.gap);
      if (!ok) begin
        bad++;
        $display("FAIL %s cmd/cke/done/ba/a/gap: actual=%0h/%0b/%0b/%0h/%0h/%0d expected=%0h/%0b/%0b/%0h/%0h/%0d",
                 e.rq, c, cke, req_done, ba, a, cyc - last_cyc, e.cmd, e.cke, e.done, e.ba, e.a, e.gap);
      end
    end
    last_cyc = cyc;
  endtask

  // monitor: pops the scoreboard as commands appear
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (cke && !prev_cke) handle(C_CKE);
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP || req_done) handle({cs_n, ras_n, cas_n, we_n});
      prev_cke = cke;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=done", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic exp_access(input bit wr, input logic [23:0] ad, input int cw, input int tw,
                            input int act_gap, input bit ck_ok, input string rq);
    int colw;
    logic [10:0] col;
    logic [1:0]  b;
    logic [12:0] row, ca;
    colw = 8 + cw;
    col  = 11'(ad & ((24'd1 << colw) - 24'd1));
    b    = 2'((ad >> colw) & 24'd3);
    row  = 13'((ad >> (colw + 2)) & 24'h1fff);
    ca   = {1'b0, col[10], 1'b0, col[9:0]};
    push(C_ACT, b, row, 1, ck_ok, 0, act_gap, rq);
    push(wr ? C_WR : C_RD, b, ca, 1, 1, 0, 2, rq);
    push(C_PRE, b, 13'h000, 1, 1, 1, wr ? ((tw == 0 ? 1 : tw) + 1) : 1, rq);
  endtask

  task automatic send_req(input bit wr, input logic [23:0] ad);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "reset cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(cke && !busy && req_ready, "R1", "reset cke/busy/ready", {cke, busy, req_ready}, 3'b101);

    // R3: arm, nothing issued, then init in front of the first access
    s_pu = 1'b1; @(negedge clk); s_pu = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy, "R3", "busy after arm only", busy, 0);
    chk(n_evt == 0, "R3", "commands after arm only", n_evt, 0);
    twr = 2'd2; col_w = 2'd0;
    push(C_PRE, 0, 13'h400, 1, 1, 0, -1, "R3");
    push(C_REF, 0, 0, 0, 1, 0, 2, "R3");
    push(C_REF, 0, 0, 0, 1, 0, 4, "R3");
    push(C_MRS, 0, 13'h020, 1, 1, 0, 4, "R3");
    exp_access(1, 24'h12345A, 0, 2, 2, 1, "R3");
    send_req(1, 24'h12345A);
    drain();

    // R4/R2: reads and writes over column widths
    col_w = 2'd1; exp_access(0, 24'h3ABCDE, 1, 2, -1, 1, "R4"); send_req(0, 24'h3ABCDE); drain();
    col_w = 2'd3; exp_access(0, 24'hABC7FF, 3, 2, -1, 1, "R2"); send_req(0, 24'hABC7FF); drain();
    col_w = 2'd2; exp_access(1, 24'h5F0F3C, 2, 2, -1, 1, "R2"); send_req(1, 24'h5F0F3C); drain();

    // R5: write recovery codes
    col_w = 2'd0;
    twr = 2'd3; exp_access(1, 24'h001122, 0, 3, -1, 1, "R5"); send_req(1, 24'h001122); drain();
    twr = 2'd0; exp_access(1, 24'h00F0F0, 0, 0, -1, 1, "R5"); send_req(1, 24'h00F0F0); drain();
    twr = 2'd1; exp_access(1, 24'h7FFFFF, 0, 1, -1, 1, "R5"); send_req(1, 24'h7FFFFF); drain();

    // R10: forced precharge, then both strobes together
    push(C_PRE, 0, 13'h400, 1, 1, 0, -1, "R10");
    s_fp = 1'b1; @(negedge clk); s_fp = 1'b0; drain();
    push(C_PRE, 0, 13'h400, 1, 1, 0, -1, "R10");
    push(C_REF, 0, 0, 0, 1, 0, 3, "R10");
    s_fp = 1'b1; s_fr = 1'b1; @(negedge clk); s_fp = 1'b0; s_fr = 1'b0; drain();

    // R9: forced refresh
    push(C_REF, 0, 0, 0, 1, 0, -1, "R9");
    s_fr = 1'b1; @(negedge clk); s_fr = 1'b0; drain();

    // R11: force during an access waits; force before a request goes first
    exp_access(1, 24'h0ABCDE, 0, 1, -1, 1, "R11");
    push(C_REF, 0, 0, 0, 1, 0, 3, "R11");
    send_req(1, 24'h0ABCDE);
    s_fr = 1'b1; @(negedge clk); s_fr = 1'b0; drain();
    push(C_PRE, 0, 13'h400, 1, 1, 0, -1, "R11");
    exp_access(0, 24'h055555, 0, 1, -1, 1, "R11");
    s_fp = 1'b1; @(negedge clk); s_fp = 1'b0;
    chk(!req_ready, "R11", "ready while force pending", req_ready, 0);
    send_req(0, 24'h055555); drain();

    // R6: self-refresh requested mid-access
    exp_access(1, 24'h0CAFE0, 0, 1, -1, 1, "R6");
    push(C_REF, 0, 0, 0, 0, 0, 3, "R6");
    send_req(1, 24'h0CAFE0);
    s_sr = 1'b1; @(negedge clk); s_sr = 1'b0; drain();
    n0 = n_evt;
    repeat (10) @(negedge clk);
    chk(!cke, "R6", "cke in self-refresh", cke, 0);
    chk(!busy && req_ready, "R6", "idle/ready in self-refresh", {busy, req_ready}, 2'b01);
    chk(n_evt == n0, "R6", "commands in self-refresh", n_evt - n0, 0);

    // R7: exit on request
    push(C_CKE, 0, 0, 0, 1, 0, -1, "R7");
    exp_access(0, 24'h0BEEF0, 0, 1, 3, 1, "R7");
    send_req(0, 24'h0BEEF0); drain();
    chk(cke, "R7", "cke after exit", cke, 1);

    // R8: periodic refresh on, then off
    push(C_REF, 0, 0, 0, 1, 0, -1, "R8");
    push(C_REF, 0, 0, 0, 1, 0, REF_P, "R8");
    ref_off = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    ref_off = 1'b1;
    n0 = n_evt;
    repeat (2 * REF_P) @(negedge clk);
    chk(n_evt == n0, "R8", "refresh while disabled", n_evt - n0, 0);
    chk(exp_q.size() == 0, "R12", "scoreboard left", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule